// File: doc/BRIEF.md
# Four-Level Strap Address Decoder

This block derives the 7-bit target address of a two-wire serial bus slave from three strap pins. Each strap pin can be tied low, tied high, or wired to the bus clock line or the bus data line, which gives four states per pin and 64 addresses in total. The block watches the already-synchronized strap pins together with the synchronized clock and data lines. It decides for each pin whether it follows one of the bus lines or holds a fixed level, and then turns the three pin states into an address.

The strap sampling window stays open until both bus lines have made a minimum number of transitions (parameter `MIN_EDGES`). When the window closes, the decoded address is latched and a valid flag rises. Both hold until reset. From then on, a protocol engine can present each first byte received after a START. The block answers with a match pulse, and with a read request when that byte asks for a read.

Top module: `strap_addr_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `addrValid`, `addrMatch` and `readReq` are 0.
- R2: `addrValid` stays 0 until, since reset, `sclIn` has made at least `MIN_EDGES` transitions and `sdaIn` has made at least `MIN_EDGES` transitions. It rises within a few cycles after both counts are reached.
- R3: A strap pin that equals `sclIn` at every sample of the window is clock-tied. Its address low bit (pin2 → bit 2, pin1 → bit 1, pin0 → bit 0) is 0.
- R4: A strap pin that equals `sdaIn` at every sample of the window, and is not clock-tied, is data-tied. Its address low bit is 1.
- R5: Any other pin is static. Its low bit is its level when the window closes (high = 1, low = 0). This includes a pin that followed a bus line for only part of the window.
- R6: When all three pins are static, `addrOut[6:3]` is 4'b0100.
- R7: With pin2 static, `addrOut[6:3]` is 4'b0101 when only pin0 is bus-tied, 4'b0010 when only pin1 is bus-tied, and 4'b0011 when pin1 and pin0 are both bus-tied.
- R8: With pin2 bus-tied, `addrOut[6:3]` is 4'b1100 when pin1 and pin0 are static, 4'b1110 when only pin0 is also bus-tied, 4'b1010 when only pin1 is also bus-tied, and 4'b1011 when all three are bus-tied.
- R9: Once `addrValid` is 1, it and `addrOut` hold until reset, whatever the strap pins and bus lines do.
- R10: One cycle after `rxStrobe`, `addrMatch` is 1 exactly when `addrValid` is 1 and `rxByte[7:1]` equals `addrOut`. `readReq` is 1 exactly when `addrMatch` is 1 and `rxByte[0]` is 1 (1 = read, 0 = write). Both are 0 in every other cycle.
- R11: `addrMatch` is never 1 while `addrValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapIn | input | 3 | Synchronized strap pins, index 2 down to 0 |
| sclIn | input | 1 | Synchronized bus clock line |
| sdaIn | input | 1 | Synchronized bus data line |
| rxByte | input | 8 | First byte after START: address in [7:1], read flag in [0] |
| rxStrobe | input | 1 | One-cycle qualifier for rxByte |
| addrOut | output | 7 | Decoded slave address |
| addrValid | output | 1 | Address decoded; sticky until reset |
| addrMatch | output | 1 | Received address equals decoded address |
| readReq | output | 1 | Matching byte requests a read |

## Verification
A tracking flag that clears wrongly, or never clears, changes how a pin is classified. That shows as a wrong address the moment `addrValid` rises, so the scoreboard compares `addrOut` in that same cycle. A window counter that closes early shows as `addrValid` rising after only three transitions on each line. A broken sticky hold shows as the address moving when the straps change after decode. A stale match register shows at the very next byte strobe.

// File: rtl/strap_pkg.sv
package strap_pkg;

  // low bit doubles as the address low bit, high bit marks bus-tied
  typedef enum logic [1:0] {
    PIN_LOW  = 2'b00,
    PIN_HIGH = 2'b01,
    PIN_CLK  = 2'b10,
    PIN_DAT  = 2'b11
  } pinState_t;

  typedef struct packed {
    logic sample;  // compare strap pins against bus lines this cycle
    logic close;   // latch classification and address this cycle
  } ctrlStrobe_t;

  // upper address nibble selected by which pins are bus-tied {p2,p1,p0}
  function automatic logic [3:0] groupBits(input logic [2:0] busMask);
    logic [3:0] nib;
    case (busMask)
      3'b000:  nib = 4'b0100;
      3'b001:  nib = 4'b0101;
      3'b010:  nib = 4'b0010;
      3'b011:  nib = 4'b0011;
      3'b100:  nib = 4'b1100;
      3'b101:  nib = 4'b1110;
      3'b110:  nib = 4'b1010;
      default: nib = 4'b1011;
    endcase
    return nib;
  endfunction

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int MIN_EDGES = 4,
  parameter int CNT_W     = $clog2(MIN_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] sclCount,
  output logic [CNT_W-1:0] sdaCount
);

  localparam logic [CNT_W-1:0] EDGE_LIMIT = CNT_W'(MIN_EDGES);

  typedef enum logic [1:0] {S_ARM, S_WATCH, S_CLOSE, S_DONE} ctrlState_t;

  ctrlState_t state;
  logic       sclPrev, sdaPrev;
  logic       sclEdge, sdaEdge;
  logic       enoughEdges;

  assign sclEdge     = (sclIn != sclPrev);
  assign sdaEdge     = (sdaIn != sdaPrev);
  assign enoughEdges = (sclCount == EDGE_LIMIT) && (sdaCount == EDGE_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_ARM;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      sclCount <= '0;
      sdaCount <= '0;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
      if (state == S_WATCH) begin
        if (sclEdge && sclCount != EDGE_LIMIT) sclCount <= sclCount + 1'b1;
        if (sdaEdge && sdaCount != EDGE_LIMIT) sdaCount <= sdaCount + 1'b1;
      end
      case (state)
        S_ARM:   state <= S_WATCH;
        S_WATCH: if (enoughEdges) state <= S_CLOSE;
        S_CLOSE: state <= S_DONE;
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    strobe.sample = (state == S_ARM) || (state == S_WATCH);
    strobe.close  = (state == S_CLOSE);
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (sclCount <= EDGE_LIMIT) && (sdaCount <= EDGE_LIMIT));

  a_r2_close_needs_edges: assert property (@(posedge clk) disable iff (!rstN)
    strobe.close |-> (sclCount == EDGE_LIMIT) && (sdaCount == EDGE_LIMIT));

  a_r9_close_once: assert property (@(posedge clk) disable iff (!rstN)
    strobe.close |=> !strobe.close && !strobe.sample);

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int NUM_PINS = 3,
  parameter int ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_PINS-1:0] strapIn,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W:0]   rxByte,
  input  logic              rxStrobe,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid,
  output logic              addrMatch,
  output logic              readReq
);

  logic [NUM_PINS-1:0]      sclFlag, sdaFlag;
  logic [NUM_PINS-1:0][1:0] pinClass;
  logic [NUM_PINS-1:0]      busMask, lowBits;
  logic [ADDR_W-1:0]        nextAddr;
  logic                     hit;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sclFlag[g] <= 1'b1;
        sdaFlag[g] <= 1'b1;
      end else if (strobe.sample) begin
        sclFlag[g] <= sclFlag[g] & (strapIn[g] == sclIn);
        sdaFlag[g] <= sdaFlag[g] & (strapIn[g] == sdaIn);
      end
    end

    assign pinClass[g] = sclFlag[g] ? PIN_CLK :
                         sdaFlag[g] ? PIN_DAT :
                         strapIn[g] ? PIN_HIGH : PIN_LOW;
    assign busMask[g]  = pinClass[g][1];
    assign lowBits[g]  = pinClass[g][0];

    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      !sclFlag[g] |=> !sclFlag[g]);
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      !sdaFlag[g] |=> !sdaFlag[g]);
  end

  assign nextAddr = {groupBits(busMask), lowBits};
  assign hit      = rxStrobe && addrValid && (rxByte[ADDR_W:1] == addrOut);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut   <= '0;
      addrValid <= 1'b0;
      addrMatch <= 1'b0;
      readReq   <= 1'b0;
    end else begin
      if (strobe.close && !addrValid) begin
        addrOut   <= nextAddr;
        addrValid <= 1'b1;
      end
      addrMatch <= hit;
      readReq   <= hit && rxByte[0];
    end
  end

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> addrValid && $stable(addrOut));

  a_r11_match_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |-> addrValid);

  a_r10_read_within_match: assert property (@(posedge clk) disable iff (!rstN)
    readReq |-> addrMatch);

  a_r10_match_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |-> $past(rxStrobe));

  a_r8_group_legal: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> addrOut[6:3] inside {4'b0100, 4'b0101, 4'b0010, 4'b0011,
                                       4'b1100, 4'b1110, 4'b1010, 4'b1011});

  a_r2_valid_after_close: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrValid) |-> $past(strobe.close));

endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder
  import strap_pkg::*;
#(
  parameter int MIN_EDGES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] strapIn,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       rxStrobe,
  output logic [6:0] addrOut,
  output logic       addrValid,
  output logic       addrMatch,
  output logic       readReq
);

  localparam int CNT_W = $clog2(MIN_EDGES + 1);

  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] sclCount, sdaCount;

  strap_ctrl #(.MIN_EDGES(MIN_EDGES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strobe(strobe), .sclCount(sclCount), .sdaCount(sdaCount)
  );

  strap_datapath #(.NUM_PINS(3), .ADDR_W(7)) u_dp (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .sclIn(sclIn), .sdaIn(sdaIn),
    .strobe(strobe), .rxByte(rxByte), .rxStrobe(rxStrobe),
    .addrOut(addrOut), .addrValid(addrValid), .addrMatch(addrMatch),
    .readReq(readReq)
  );

  a_r2_edges_seen: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (sclCount == CNT_W'(MIN_EDGES)) && (sdaCount == CNT_W'(MIN_EDGES)));

endmodule

// File: tb/sim_strap_addr_decoder.sv
`timescale 1ns/1ps
module sim_strap_addr_decoder;

  localparam int CFG_LOW = 0, CFG_HIGH = 1, CFG_CLK = 2, CFG_DAT = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] strapIn;
  logic       sclIn, sdaIn;
  logic [7:0] rxByte;
  logic       rxStrobe;
  logic [6:0] addrOut;
  logic       addrValid, addrMatch, readReq;

  int cfg [3];
  int total = 0;
  int bad   = 0;
  logic [6:0] expQ [$];
  logic prevValid;

  always #2.5 clk = ~clk;

  strap_addr_decoder #(.MIN_EDGES(4)) u0 (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .rxStrobe(rxStrobe), .addrOut(addrOut),
    .addrValid(addrValid), .addrMatch(addrMatch), .readReq(readReq)
  );

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      case (cfg[i])
        CFG_LOW:  strapIn[i] = 1'b0;
        CFG_HIGH: strapIn[i] = 1'b1;
        CFG_CLK:  strapIn[i] = sclIn;
        default:  strapIn[i] = sdaIn;
      endcase
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] expAddr(input int c2, input int c1, input int c0);
    logic b2, b1, b0;
    logic [3:0] up;
    b2 = (c2 >= CFG_CLK); b1 = (c1 >= CFG_CLK); b0 = (c0 >= CFG_CLK);
    if (!b2) begin
      if (!b1) up = b0 ? 4'b0101 : 4'b0100;   // R6, R7
      else     up = b0 ? 4'b0011 : 4'b0010;   // R7
    end else begin
      if (!b1) up = b0 ? 4'b1110 : 4'b1100;   // R8
      else     up = b0 ? 4'b1011 : 4'b1010;   // R8
    end
    // R3, R4, R5: data-tied and high read 1
    return {up, (c2 == CFG_HIGH || c2 == CFG_DAT), (c1 == CFG_HIGH || c1 == CFG_DAT),
            (c0 == CFG_HIGH || c0 == CFG_DAT)};
  endfunction

  // scoreboard monitor: compare address when valid first rises
  always @(negedge clk) begin
    if (rstN !== 1'b1) prevValid <= 1'b0;
    else begin
      if (addrValid && !prevValid) begin
        if (expQ.size() == 0) check(1'b0, "R3/R4/R5 unexpected decode", addrOut, 0);
        else begin
          logic [6:0] e;
          e = expQ.pop_front();
          check(addrOut == e, "R3-R8 decoded address", addrOut, e);
        end
      end
      prevValid <= addrValid;
    end
  end

  task automatic doReset();
    rstN = 1'b0; sclIn = 1'b1; sdaIn = 1'b1; rxByte = '0; rxStrobe = 1'b0;
    repeat (3) @(negedge clk);
    check(addrValid == 0 && addrMatch == 0 && readReq == 0, "R1 in reset",
          {addrValid, addrMatch, readReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(addrValid == 0 && addrMatch == 0 && readReq == 0, "R1 after reset",
          {addrValid, addrMatch, readReq}, 0);
  endtask

  task automatic toggle(input int n);
    for (int k = 0; k < n; k++) begin
      sdaIn = ~sdaIn; repeat (2) @(negedge clk);
      sclIn = ~sclIn; repeat (2) @(negedge clk);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expM, input logic expR, input string req);
    rxByte = b; rxStrobe = 1'b1;
    @(negedge clk);
    rxStrobe = 1'b0;
    check(addrMatch == expM && readReq == expR, req, {addrMatch, readReq}, {expM, expR});
    @(negedge clk);
    check(addrMatch == 0 && readReq == 0, "R10 one-cycle pulse", {addrMatch, readReq}, 0);
  endtask

  task automatic runCase(input int c2, input int c1, input int c0, input int late0);
    logic [6:0] e;
    cfg[2] = c2; cfg[1] = c1; cfg[0] = c0;
    e = expAddr(c2, c1, late0);
    doReset();
    toggle(3);
    check(addrValid == 0, "R2 too few edges", addrValid, 0);
    sendByte({e, 1'b1}, 1'b0, 1'b0, "R11 no match before valid");
    cfg[0] = late0;  // R5: a pin leaving its bus line mid-window ends static
    expQ.push_back(e);
    toggle(2);
    repeat (6) @(negedge clk);
    check(addrValid == 1, "R2 valid after edges", addrValid, 1);
    sendByte({e, 1'b1}, 1'b1, 1'b1, "R10 read match");
    sendByte({e, 1'b0}, 1'b1, 1'b0, "R10 write match");
    sendByte({e ^ 7'h01, 1'b1}, 1'b0, 1'b0, "R10 mismatch low bit");
    sendByte({e ^ 7'h40, 1'b0}, 1'b0, 1'b0, "R10 mismatch high bit");
    cfg[2] = (c2 + 1) % 4; cfg[1] = (c1 + 2) % 4; cfg[0] = (late0 + 3) % 4;
    toggle(3);
    check(addrValid == 1 && addrOut == e, "R9 address holds", addrOut, e);
  endtask

  initial begin
    cfg[0] = CFG_HIGH; cfg[1] = CFG_HIGH; cfg[2] = CFG_HIGH;
    prevValid = 1'b0;
    runCase(CFG_HIGH, CFG_LOW,  CFG_HIGH, CFG_HIGH);  // R6, R5
    runCase(CFG_LOW,  CFG_LOW,  CFG_DAT,  CFG_DAT);   // R7, R4
    runCase(CFG_LOW,  CFG_CLK,  CFG_HIGH, CFG_HIGH);  // R7, R3
    runCase(CFG_HIGH, CFG_DAT,  CFG_CLK,  CFG_CLK);   // R7
    runCase(CFG_CLK,  CFG_DAT,  CFG_LOW,  CFG_LOW);   // R8
    runCase(CFG_DAT,  CFG_DAT,  CFG_DAT,  CFG_DAT);   // R8
    runCase(CFG_DAT,  CFG_LOW,  CFG_HIGH, CFG_HIGH);  // R8
    runCase(CFG_CLK,  CFG_HIGH, CFG_DAT,  CFG_DAT);   // R8
    runCase(CFG_LOW,  CFG_LOW,  CFG_CLK,  CFG_LOW);   // R5 partial follower
    runCase(CFG_CLK,  CFG_CLK,  CFG_CLK,  CFG_CLK);   // R8, R3
    check(expQ.size() == 0, "R2 every case decoded", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule